// File: doc/BRIEF.md
# Run-Time Selectable CRC Accumulator

This block computes a running CRC over words written to it through a simple register bus. A small mode register picks one of three common generator polynomials and turns on four independent transforms. On the way in, each byte can be bit-mirrored and then inverted. On the way out, the sum can be mirrored and inverted.

Software works in three steps:
- Write a start value to the seed address.
- Write data as 8-, 16- or 32-bit accesses to the data address.
- Read the sum back from any non-mode address.

The engine takes one byte per clock, most significant byte first. It raises `busy` while bytes remain. A write of any kind is accepted only on a clock edge where `busy` is low; until then the initiator must keep the request asserted.

Top module: `crc_accel`

## Requirements
- R1: After reset, `busy` is low, the mode register reads 0 and the sum reads 0. A read at address 0 returns the mode register; a read at any other address returns the sum view.
- R2: A write to address 0 sets the mode register, and a write to address 2 feeds data. Mode bits [1:0] select the polynomial: 00 gives 0x1021 (16-bit), 01 gives 0x8005 (16-bit), and 1x gives 0x04C11DB7 (32-bit). Bits are fed MSB-first with no implicit reflection.
- R3: With mode bit 2 set, each data byte is bit-mirrored before it enters the CRC.
- R4: With mode bit 3 set, each data byte is inverted before it enters the CRC. This inversion is applied after any mirroring.
- R5: With mode bit 4 set, the sum view is bit-mirrored across the active polynomial width (16 or 32 bits).
- R6: With mode bit 5 set, the sum view is inverted across the active width. Both output transforms change only the view, never the accumulator.
- R7: Mode bits [31:6] ignore writes and read as zero.
- R8: A write to address 1 loads the written word into the accumulator directly.
- R9: Writing the mode register leaves the accumulator unchanged.
- R10: `bus_size` selects the data width: 00 is one byte (bits [7:0]), 01 is two bytes (bits [15:0]), and 10 or 11 is four bytes. Bytes are processed most significant first, one per clock. `busy` is high for exactly as many cycles as there are bytes, starting the cycle after acceptance.
- R11: A write presented while `busy` is high is not accepted and has no effect on the mode register or the accumulator.
- R12: With a 16-bit polynomial selected, sum bits [31:16] read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, accepted when busy is low |
| bus_addr | input | 2 | 0 mode, 1 seed, 2 data; also selects the read source |
| bus_size | input | 2 | Data write width: 00 byte, 01 halfword, 1x word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Mode register at address 0, sum view elsewhere |
| busy | output | 1 | High while buffered bytes remain to be processed |

## Verification
The bench checks published check values for the string "123456789" under several polynomial and reflection settings. A swapped polynomial code, a mirror applied across the wrong width or a missing final inversion would each produce a wrong known value.

A sweep of all 64 mode codes with mixed access widths compares every sum against a bit-serial model. This catches byte order reversed within a word, an input transform skipped, or the inversion and mirror applied in the wrong place.

Directed cases cover the following:
- The seed path and the accumulator left untouched by mode writes; a design that recomputed the accumulator would fail here.
- Upper bits reading zero in 16-bit mode.
- The exact `busy` length for each width.
- Mode and data writes presented while busy; a design that accepted these would change the mode or the sum.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int MODE_W = 6;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_SEED = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam logic [15:0] POLY_CCITT16 = 16'h1021;
    localparam logic [15:0] POLY_ARC16   = 16'h8005;
    localparam logic [31:0] POLY_ETH32   = 32'h04C1_1DB7;

    typedef struct packed {
        logic       out_inv;
        logic       out_mirror;
        logic       in_inv;
        logic       in_mirror;
        logic [1:0] poly_sel;
    } mode_t;

endpackage

// File: rtl/crc_in_prep.sv
module crc_in_prep #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              mirror,
    input  logic              invert,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] flipped;

    for (genvar i = 0; i < BYTE_W; i++) begin : g_flip
        assign flipped[i] = byte_in[BYTE_W-1-i];
    end

    always_comb begin
        byte_out = mirror ? flipped : byte_in;
        if (invert) begin
            byte_out = ~byte_out;
        end
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int W      = 32,
    parameter int BYTE_W = 8
) (
    input  logic [W-1:0]      crc_in,
    input  logic [W-1:0]      poly,
    input  logic [BYTE_W-1:0] data,
    output logic [W-1:0]      crc_out
);
    always_comb begin
        logic fb;
        crc_out = crc_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb      = crc_out[W-1] ^ data[i];
            crc_out = {crc_out[W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
    end
endmodule

// File: rtl/crc_sum_view.sv
module crc_sum_view #(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic              wide,
    input  logic              mirror,
    input  logic              invert,
    output logic [DATA_W-1:0] view
);
    logic [DATA_W-1:0]   acc_rev_w;
    logic [NARROW_W-1:0] acc_rev_n;
    logic [DATA_W-1:0]   mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev_w
        assign acc_rev_w[i] = acc[DATA_W-1-i];
    end
    for (genvar j = 0; j < NARROW_W; j++) begin : g_rev_n
        assign acc_rev_n[j] = acc[NARROW_W-1-j];
    end

    always_comb begin
        mask = wide ? '1 : DATA_W'({NARROW_W{1'b1}});
        if (mirror) begin
            view = wide ? acc_rev_w : DATA_W'(acc_rev_n);
        end else begin
            view = acc & mask;
        end
        if (invert) begin
            view = view ^ mask;
        end
    end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BYTE_W   = 8,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy
);
    localparam int BYTES = DATA_W / BYTE_W;
    localparam int CNT_W = $clog2(BYTES + 1);

    typedef struct packed {
        mode_t             mode;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t d, q;

    logic              accept;
    logic [CNT_W-1:0]  n_bytes;
    logic [BYTE_W-1:0] raw_byte, prep_byte;
    logic [NARROW_W-1:0] poly_n, step_n;
    logic [DATA_W-1:0]   step_w, view;

    assign busy     = (q.cnt != '0);
    assign accept   = bus_wr && !busy;
    assign raw_byte = q.hold[DATA_W-1 -: BYTE_W];
    assign poly_n   = q.mode.poly_sel[0] ? NARROW_W'(POLY_ARC16) : NARROW_W'(POLY_CCITT16);

    always_comb begin
        case (bus_size)
            2'b00:   n_bytes = CNT_W'(1);
            2'b01:   n_bytes = CNT_W'(2);
            default: n_bytes = CNT_W'(BYTES);
        endcase
    end

    crc_in_prep #(.BYTE_W(BYTE_W)) u_prep (
        .byte_in (raw_byte),
        .mirror  (q.mode.in_mirror),
        .invert  (q.mode.in_inv),
        .byte_out(prep_byte)
    );

    crc_byte_step #(.W(NARROW_W), .BYTE_W(BYTE_W)) u_step_n (
        .crc_in (q.acc[NARROW_W-1:0]),
        .poly   (poly_n),
        .data   (prep_byte),
        .crc_out(step_n)
    );

    crc_byte_step #(.W(DATA_W), .BYTE_W(BYTE_W)) u_step_w (
        .crc_in (q.acc),
        .poly   (DATA_W'(POLY_ETH32)),
        .data   (prep_byte),
        .crc_out(step_w)
    );

    crc_sum_view #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_view (
        .acc   (q.acc),
        .wide  (q.mode.poly_sel[1]),
        .mirror(q.mode.out_mirror),
        .invert(q.mode.out_inv),
        .view  (view)
    );

    always_comb begin
        d = q;
        if (busy) begin
            d.acc  = q.mode.poly_sel[1] ? step_w : DATA_W'(step_n);
            d.hold = q.hold << BYTE_W;
            d.cnt  = q.cnt - 1'b1;
        end else if (accept) begin
            case (bus_addr)
                ADDR_MODE: d.mode = mode_t'(bus_wdata[MODE_W-1:0]);
                ADDR_SEED: d.acc  = bus_wdata;
                ADDR_DATA: begin
                    d.hold = bus_wdata << (BYTE_W * (BYTES - int'(n_bytes)));
                    d.cnt  = n_bytes;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata = (bus_addr == ADDR_MODE) ? DATA_W'(q.mode) : view;

    assert_seed_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_addr == ADDR_SEED) |=> (q.acc == $past(bus_wdata)));

    assert_mode_keeps_acc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_addr == ADDR_MODE) |=> $stable(q.acc));

    assert_stall_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy) |=> $stable(q.mode));

    assert_data_starts_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bus_addr == ADDR_DATA) |=> busy);

    assert_narrow_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !q.mode.poly_sel[1]) |=> (q.acc[DATA_W-1:NARROW_W] == '0));

    assert_view_narrow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_MODE && !q.mode.poly_sel[1]) |-> (bus_rdata[DATA_W-1:NARROW_W] == '0));
endmodule

// File: tb/crc_accel_tb.sv
`timescale 1ns/1ps
module crc_accel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_acc = 32'd0;
    logic [5:0]  m_mode = 6'd0;

    always #4 clk = ~clk;

    crc_accel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_byte(input logic [31:0] acc, input logic [7:0] b,
                                             input logic [5:0] m);
        logic [7:0]  x;
        logic [31:0] poly;
        logic        top;
        int          w;
        x = b;
        if (m[2]) for (int i = 0; i < 8; i++) x[i] = b[7-i];
        if (m[3]) x = ~x;
        if (m[1])      begin w = 32; poly = 32'h04C11DB7; end
        else if (m[0]) begin w = 16; poly = 32'h00008005; end
        else           begin w = 16; poly = 32'h00001021; end
        if (w == 16) acc = acc & 32'hFFFF;
        for (int i = 7; i >= 0; i--) begin
            top = acc[w-1] ^ x[i];
            acc = acc << 1;
            if (w == 16) acc = acc & 32'hFFFF;
            if (top) acc = acc ^ poly;
        end
        return acc;
    endfunction

    function automatic logic [31:0] ref_view(input logic [31:0] acc, input logic [5:0] m);
        int w;
        logic [31:0] v, r, mask;
        w    = m[1] ? 32 : 16;
        mask = (w == 32) ? 32'hFFFFFFFF : 32'h0000FFFF;
        v    = acc & mask;
        if (m[4]) begin
            r = 32'd0;
            for (int i = 0; i < w; i++) r[w-1-i] = v[i];
            v = r;
        end
        if (m[5]) v = v ^ mask;
        return v;
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] dat,
                             output int bcyc);
        int n;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = dat;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        bcyc = 0;
        while (busy) begin bcyc++; @(negedge clk); end
        if (a == 2'd0) m_mode = dat[5:0];
        else if (a == 2'd1) m_acc = dat;
        else if (a == 2'd2) begin
            n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
            for (int k = n - 1; k >= 0; k--) m_acc = ref_byte(m_acc, dat[8*k +: 8], m_mode);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] dat);
        int bc;
        bus_write(a, sz, dat, bc);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic feed_check_string();
        wr(2'd2, 2'b10, 32'h31323334);
        wr(2'd2, 2'b10, 32'h35363738);
        wr(2'd2, 2'b00, 32'h00000039);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        rd(2'd0, v); chk("R1 mode reset", v, 32'd0);
        rd(2'd1, v); chk("R1 sum reset", v, 32'd0);
        rd(2'd3, v); chk("R1 sum at addr3", v, 32'd0);
    endtask

    task automatic t_known();
        logic [31:0] v;
        wr(2'd0, 2'b10, 32'h02); wr(2'd1, 2'b10, 32'hFFFFFFFF); feed_check_string();
        rd(2'd2, v); chk("R2 crc32 plain", v, 32'h0376E6E7);
        wr(2'd0, 2'b10, 32'h36); wr(2'd1, 2'b10, 32'hFFFFFFFF); feed_check_string();
        rd(2'd2, v); chk("R3 R5 R6 crc32 reflected", v, 32'hCBF43926);
        wr(2'd0, 2'b10, 32'h00); wr(2'd1, 2'b10, 32'h0000FFFF); feed_check_string();
        rd(2'd2, v); chk("R2 ccitt", v, 32'h000029B1);
        wr(2'd0, 2'b10, 32'h15); wr(2'd1, 2'b10, 32'h0); feed_check_string();
        rd(2'd2, v); chk("R2 R3 R5 crc16 reflected", v, 32'h0000BB3D);
    endtask

    task automatic t_all_modes();
        logic [31:0] v;
        for (int m = 0; m < 64; m++) begin
            wr(2'd0, 2'b10, 32'(m));
            rd(2'd0, v); chk("R2 mode readback", v, 32'(m));
            wr(2'd1, 2'b10, 32'hA5C31E77);
            wr(2'd2, 2'b10, 32'hDEADBEEF);
            wr(2'd2, 2'b01, 32'hFFFF1234);
            wr(2'd2, 2'b00, 32'h0000C05A);
            rd(2'd2, v); chk("R3 R4 R5 R6 R10 sweep", v, ref_view(m_acc, m_mode));
        end
    endtask

    task automatic t_seed_mode();
        logic [31:0] v;
        wr(2'd0, 2'b10, 32'h02); wr(2'd1, 2'b10, 32'h89ABCDEF);
        rd(2'd1, v); chk("R8 seed load", v, 32'h89ABCDEF);
        wr(2'd0, 2'b10, 32'h22);
        rd(2'd1, v); chk("R6 R9 inverted view", v, 32'h76543210);
        wr(2'd0, 2'b10, 32'h02);
        rd(2'd1, v); chk("R6 R9 acc untouched", v, 32'h89ABCDEF);
        wr(2'd0, 2'b10, 32'hFFFFFFC5);
        rd(2'd0, v); chk("R7 upper mode bits", v, 32'h00000005);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        wr(2'd0, 2'b10, 32'h00); wr(2'd1, 2'b10, 32'hFFFFFFFF);
        rd(2'd1, v); chk("R12 narrow mask", v, 32'h0000FFFF);
        wr(2'd0, 2'b10, 32'h30); wr(2'd1, 2'b10, 32'h12345678);
        rd(2'd1, v); chk("R5 R6 R12 narrow mirror invert", v, 32'h0000E195);
        wr(2'd2, 2'b10, 32'hCAFEF00D);
        rd(2'd1, v); chk("R12 narrow after data", v, ref_view(m_acc, m_mode));
    endtask

    task automatic t_busy();
        int bc;
        wr(2'd0, 2'b10, 32'h01);
        bus_write(2'd2, 2'b00, 32'h11, bc); chk("R10 busy byte", 32'(bc), 32'd1);
        bus_write(2'd2, 2'b01, 32'h1122, bc); chk("R10 busy half", 32'(bc), 32'd2);
        bus_write(2'd2, 2'b10, 32'h11223344, bc); chk("R10 busy word", 32'(bc), 32'd4);
        bus_write(2'd2, 2'b11, 32'h55667788, bc); chk("R10 busy size3", 32'(bc), 32'd4);
        bus_write(2'd0, 2'b10, 32'h02, bc); chk("R10 mode no busy", 32'(bc), 32'd0);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        wr(2'd0, 2'b10, 32'h02); wr(2'd1, 2'b10, 32'h0BADF00D);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd2; bus_size = 2'b10; bus_wdata = 32'h01020304;
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 32'h3F;
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        while (busy) @(negedge clk);
        m_acc = 32'h0BADF00D;
        for (int k = 3; k >= 0; k--) m_acc = ref_byte(m_acc, 8'(32'h01020304 >> (8*k)), m_mode);
        rd(2'd0, v); chk("R11 mode stalled", v, 32'h02);
        rd(2'd2, v); chk("R11 sum stalled", v, m_acc);
    endtask

    initial begin
        #(8.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_known();
        t_all_modes();
        t_seed_mode();
        t_narrow();
        t_busy();
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule